// File: doc/BRIEF.md
# Flag-Generating 16-bit ALU with Single-Bit Shifter

This block is the arithmetic core of a small RISC processor. It takes two operands and produces one result without a clock. An adder/subtractor, a three-function logic unit, a one-position shifter and a direct copy of the second operand all compute in parallel. A 2-bit output select picks which of these drives the result. The shift direction follows the sign of the shift instruction's immediate operand, which reaches the block as a single bit.

Four condition flags (carry, overflow, zero, negative) are derived from the adder path. A small status register stores them. The register loads only on a clock edge where the flag enable is high and the adder is the selected output. Every other operation leaves the stored flags as they were. A synchronous reset clears the stored flags.

Top module: `alu16_flags`

## Requirements
- R1: With out_sel = 2'b01 and sub_mode = 0, result equals op_a + op_b modulo 2^16.
- R2: With out_sel = 2'b01 and sub_mode = 1, result equals op_a + ~op_b + 1 modulo 2^16, which is op_a - op_b.
- R3: With out_sel = 2'b00, result is the bitwise function chosen by logic_sel: 2'b00 AND, 2'b01 OR, 2'b10 XOR, 2'b11 AND.
- R4: With out_sel = 2'b10, result is op_a moved by exactly one bit with a zero shifted in. The move is toward the MSB when shift_imm_neg = 0 and toward the LSB when shift_imm_neg = 1.
- R5: With out_sel = 2'b11, result equals op_b unchanged.
- R6: A stored carry flag equals the adder's raw carry-out XOR sub_mode.
- R7: A stored overflow flag is set exactly when the add or subtract overflows as a signed 16-bit operation.
- R8: A stored zero flag is 1 exactly when all 16 result bits are 0.
- R9: A stored negative flag equals the raw adder carry-out XOR op_a[15] XOR op_b[15].
- R10: The flags load on a rising clock edge only when flag_en = 1 and out_sel = 2'b01. Otherwise they keep their values, and they appear at the flag outputs one cycle after the operands.
- R11: When rst = 1 at a rising edge, all four flags become 0, even if a flag load is requested in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the status register |
| rst | input | 1 | Synchronous active-high reset of the flags |
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| sub_mode | input | 1 | 1 selects subtraction, 0 addition |
| logic_sel | input | 2 | Logic function select |
| out_sel | input | 2 | Result source select |
| shift_imm_neg | input | 1 | Sign of the shift immediate (1 = shift toward LSB) |
| flag_en | input | 1 | Allows the status register to load |
| result | output | 16 | Selected result |
| carry_q | output | 1 | Stored carry flag |
| ovf_q | output | 1 | Stored overflow flag |
| zero_q | output | 1 | Stored zero flag |
| neg_q | output | 1 | Stored negative flag |

## Verification
Two events can meet in one cycle: a flag load requested by an adder operation, and a synchronous reset. The bench first drives an operation that sets all four flags (0x8000 + 0x8000). It then presents the same load request with reset held high. It expects every flag to read 0 after that edge. A flag-enabled logic, shift or pass-through operation that follows a flag-setting subtraction shows whether the load gate wrongly lets non-adder results through.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

    typedef enum logic [1:0] {
        OUT_LOGIC = 2'b00,
        OUT_ARITH = 2'b01,
        OUT_SHIFT = 2'b10,
        OUT_PASSB = 2'b11
    } out_sel_e;

    typedef enum logic [1:0] {
        LG_AND     = 2'b00,
        LG_OR      = 2'b01,
        LG_XOR     = 2'b10,
        LG_AND_ALT = 2'b11
    } logic_sel_e;

    typedef struct packed {
        logic carry;
        logic ovf;
        logic zero;
        logic neg;
    } flags_t;

    localparam flags_t FLAGS_CLEAR = '{carry: 1'b0, ovf: 1'b0, zero: 1'b0, neg: 1'b0};

    function automatic logic signed_ovf(input logic a_msb, input logic b_eff_msb,
                                        input logic s_msb);
        return (a_msb == b_eff_msb) && (s_msb != a_msb);
    endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int unsigned WIDTH = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             sub,
    output logic [WIDTH-1:0] sum,
    output logic             cout,
    output logic             ovf
);
    import alu16_pkg::*;

    localparam int unsigned MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;
    logic [WIDTH:0]   wide;

    always_comb begin
        b_eff = b ^ {WIDTH{sub}};
        wide  = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub};
        sum   = wide[WIDTH-1:0];
        cout  = wide[WIDTH];
        ovf   = signed_ovf(a[MSB], b_eff[MSB], wide[MSB]);
    end
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
    parameter int unsigned WIDTH = 16
) (
    input  logic [WIDTH-1:0]       a,
    input  logic [WIDTH-1:0]       b,
    input  alu16_pkg::logic_sel_e  sel,
    output logic [WIDTH-1:0]       y
);
    import alu16_pkg::*;

    always_comb begin
        unique case (sel)
            LG_OR:   y = a | b;
            LG_XOR:  y = a ^ b;
            default: y = a & b;
        endcase
    end
endmodule

// File: rtl/alu_shift1.sv
module alu_shift1 #(
    parameter int unsigned WIDTH = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic             toward_lsb,
    output logic [WIDTH-1:0] y
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic from_low;
        logic from_high;
        if (i == 0) begin : g_lo_edge
            assign from_low = 1'b0;
        end else begin : g_lo_mid
            assign from_low = a[i-1];
        end
        if (i == WIDTH - 1) begin : g_hi_edge
            assign from_high = 1'b0;
        end else begin : g_hi_mid
            assign from_high = a[i+1];
        end
        assign y[i] = toward_lsb ? from_high : from_low;
    end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  alu16_pkg::flags_t d,
    output alu16_pkg::flags_t q
);
    import alu16_pkg::*;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= FLAGS_CLEAR;
        end else if (load) begin
            q <= d;
        end
    end
endmodule

// File: rtl/alu16_flags.sv
module alu16_flags #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             sub_mode,
    input  logic [1:0]       logic_sel,
    input  logic [1:0]       out_sel,
    input  logic             shift_imm_neg,
    input  logic             flag_en,
    output logic [WIDTH-1:0] result,
    output logic             carry_q,
    output logic             ovf_q,
    output logic             zero_q,
    output logic             neg_q
);
    import alu16_pkg::*;

    localparam int unsigned MSB = WIDTH - 1;

    out_sel_e         osel;
    logic_sel_e       lsel;
    logic [WIDTH-1:0] add_sum;
    logic             add_cout;
    logic             add_ovf;
    logic [WIDTH-1:0] logic_y;
    logic [WIDTH-1:0] shift_y;
    flags_t           flags_next;
    flags_t           flags_q;
    logic             flag_load;

    assign osel = out_sel_e'(out_sel);
    assign lsel = logic_sel_e'(logic_sel);

    alu_addsub #(.WIDTH(WIDTH)) u_add (
        .a    (op_a),
        .b    (op_b),
        .sub  (sub_mode),
        .sum  (add_sum),
        .cout (add_cout),
        .ovf  (add_ovf)
    );

    alu_logic #(.WIDTH(WIDTH)) u_logic (
        .a   (op_a),
        .b   (op_b),
        .sel (lsel),
        .y   (logic_y)
    );

    alu_shift1 #(.WIDTH(WIDTH)) u_shift (
        .a          (op_a),
        .toward_lsb (shift_imm_neg),
        .y          (shift_y)
    );

    always_comb begin
        unique case (osel)
            OUT_LOGIC: result = logic_y;
            OUT_ARITH: result = add_sum;
            OUT_SHIFT: result = shift_y;
            default:   result = op_b;
        endcase
    end

    always_comb begin
        flags_next.carry = add_cout ^ sub_mode;
        flags_next.ovf   = add_ovf;
        flags_next.zero  = ~|result;
        flags_next.neg   = add_cout ^ op_a[MSB] ^ op_b[MSB];
    end

    assign flag_load = flag_en && (osel == OUT_ARITH);

    alu_flag_reg u_flags (
        .clk  (clk),
        .rst  (rst),
        .load (flag_load),
        .d    (flags_next),
        .q    (flags_q)
    );

    assign carry_q = flags_q.carry;
    assign ovf_q   = flags_q.ovf;
    assign zero_q  = flags_q.zero;
    assign neg_q   = flags_q.neg;
endmodule

// File: rtl/alu16_flags_chk.sv
module alu16_flags_chk #(
    parameter int unsigned WIDTH = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic             sub_mode,
    input logic [1:0]       out_sel,
    input logic             flag_en,
    input logic [WIDTH-1:0] result,
    input logic             add_cout,
    input logic             carry_q,
    input logic             ovf_q,
    input logic             zero_q,
    input logic             neg_q
);
    localparam int unsigned MSB = WIDTH - 1;

    logic upd;
    assign upd = flag_en && (out_sel == 2'b01);

    p_add_result_r1: assert property (@(posedge clk) disable iff (rst)
        (out_sel == 2'b01 && !sub_mode) |-> result == WIDTH'(op_a + op_b));

    p_carry_flag_r6: assert property (@(posedge clk) disable iff (rst)
        upd |=> carry_q == ($past(add_cout) ^ $past(sub_mode)));

    p_signed_ovf_r7: assert property (@(posedge clk) disable iff (rst)
        upd |=> ovf_q == (($past(op_a[MSB]) == ($past(op_b[MSB]) ^ $past(sub_mode)))
                          && ($past(result[MSB]) != $past(op_a[MSB]))));

    p_zero_flag_r8: assert property (@(posedge clk) disable iff (rst)
        upd |=> zero_q == ($past(result) == '0));

    p_neg_flag_r9: assert property (@(posedge clk) disable iff (rst)
        upd |=> neg_q == ($past(add_cout) ^ $past(op_a[MSB]) ^ $past(op_b[MSB])));

    p_flags_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !upd |=> $stable({carry_q, ovf_q, zero_q, neg_q}));

    p_reset_clear_r11: assert property (@(posedge clk)
        rst |=> {carry_q, ovf_q, zero_q, neg_q} == 4'b0000);
endmodule

bind alu16_flags alu16_flags_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .op_a     (op_a),
    .op_b     (op_b),
    .sub_mode (sub_mode),
    .out_sel  (out_sel),
    .flag_en  (flag_en),
    .result   (result),
    .add_cout (add_cout),
    .carry_q  (carry_q),
    .ovf_q    (ovf_q),
    .zero_q   (zero_q),
    .neg_q    (neg_q)
);

// File: tb/tb_alu16_flags.sv
module tb_alu16_flags;

    typedef struct packed {
        logic [15:0] a;
        logic [15:0] b;
        logic        sub;
        logic [1:0]  lsel;
        logic [1:0]  osel;
        logic        sneg;
        logic        en;
        logic [15:0] exp_res;
        logic [3:0]  exp_flags;  // {carry, ovf, zero, neg} after the edge
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{16'h0001, 16'h0002, 1'b0, 2'd0, 2'd1, 1'b0, 1'b1, 16'h0003, 4'b0000}, // R1
        '{16'hFFFF, 16'h0001, 1'b0, 2'd0, 2'd1, 1'b0, 1'b1, 16'h0000, 4'b1010}, // R1 R6 R8
        '{16'h7FFF, 16'h0001, 1'b0, 2'd0, 2'd1, 1'b0, 1'b1, 16'h8000, 4'b0100}, // R7
        '{16'h0005, 16'h0003, 1'b1, 2'd0, 2'd1, 1'b0, 1'b1, 16'h0002, 4'b0001}, // R2 R9
        '{16'h0003, 16'h0005, 1'b1, 2'd0, 2'd1, 1'b0, 1'b1, 16'hFFFE, 4'b1000}, // R2 R6
        '{16'h8000, 16'h0001, 1'b1, 2'd0, 2'd1, 1'b0, 1'b1, 16'h7FFF, 4'b0100}, // R2 R7
        '{16'h1234, 16'h1234, 1'b1, 2'd0, 2'd1, 1'b0, 1'b1, 16'h0000, 4'b0011}, // R2 R8
        '{16'hF0F0, 16'h3C3C, 1'b0, 2'd0, 2'd0, 1'b0, 1'b1, 16'h3030, 4'b0011}, // R3 R10
        '{16'hF0F0, 16'h0F00, 1'b0, 2'd1, 2'd0, 1'b0, 1'b1, 16'hFFF0, 4'b0011}, // R3
        '{16'hFF00, 16'h0FF0, 1'b0, 2'd2, 2'd0, 1'b0, 1'b1, 16'hF0F0, 4'b0011}, // R3
        '{16'h00FF, 16'h0F0F, 1'b0, 2'd3, 2'd0, 1'b0, 1'b1, 16'h000F, 4'b0011}, // R3
        '{16'h8001, 16'h0000, 1'b0, 2'd0, 2'd2, 1'b0, 1'b1, 16'h0002, 4'b0011}, // R4
        '{16'h8001, 16'h0000, 1'b0, 2'd0, 2'd2, 1'b1, 1'b1, 16'h4000, 4'b0011}, // R4
        '{16'h0000, 16'hBEEF, 1'b0, 2'd0, 2'd3, 1'b0, 1'b1, 16'hBEEF, 4'b0011}, // R5
        '{16'hFFFF, 16'hFFFF, 1'b0, 2'd0, 2'd1, 1'b0, 1'b0, 16'hFFFE, 4'b0011}, // R10
        '{16'hFFFF, 16'hFFFF, 1'b0, 2'd0, 2'd1, 1'b0, 1'b1, 16'hFFFE, 4'b1001}, // R9
        '{16'h8000, 16'h8000, 1'b0, 2'd0, 2'd1, 1'b0, 1'b1, 16'h0000, 4'b1111}  // R6 R7 R8 R9
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] op_a = '0;
    logic [15:0] op_b = '0;
    logic        sub_mode = 1'b0;
    logic [1:0]  logic_sel = '0;
    logic [1:0]  out_sel = '0;
    logic        shift_imm_neg = 1'b0;
    logic        flag_en = 1'b0;
    logic [15:0] result;
    logic        carry_q, ovf_q, zero_q, neg_q;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    alu16_flags dut (
        .clk           (clk),
        .rst           (rst),
        .op_a          (op_a),
        .op_b          (op_b),
        .sub_mode      (sub_mode),
        .logic_sel     (logic_sel),
        .out_sel       (out_sel),
        .shift_imm_neg (shift_imm_neg),
        .flag_en       (flag_en),
        .result        (result),
        .carry_q       (carry_q),
        .ovf_q         (ovf_q),
        .zero_q        (zero_q),
        .neg_q         (neg_q)
    );

    function automatic string req_of(input logic [1:0] osel, input logic sub);
        case (osel)
            2'd0: return "R3";
            2'd2: return "R4";
            2'd3: return "R5";
            default: return sub ? "R2" : "R1";
        endcase
    endfunction

    task automatic check16(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s result: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_flags(input string req, input logic [3:0] exp);
        logic [3:0] act;
        act = {carry_q, ovf_q, zero_q, neg_q};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s flags cvzn: actual %b expected %b", req, act, exp);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check_flags("R11 reset state", 4'b0000);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            op_a = VECS[i].a;
            op_b = VECS[i].b;
            sub_mode = VECS[i].sub;
            logic_sel = VECS[i].lsel;
            out_sel = VECS[i].osel;
            shift_imm_neg = VECS[i].sneg;
            flag_en = VECS[i].en;
            #1;
            check16(req_of(VECS[i].osel, VECS[i].sub), result, VECS[i].exp_res);
            @(posedge clk);
            #1;
            check_flags("R6/R7/R8/R9/R10", VECS[i].exp_flags);
        end

        // R11: reset and a flag-setting load request in the same cycle
        @(negedge clk);
        op_a = 16'h8000; op_b = 16'h8000; sub_mode = 1'b0;
        out_sel = 2'd1; flag_en = 1'b1; rst = 1'b1;
        @(posedge clk);
        #1;
        check_flags("R11 reset beats load", 4'b0000);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check_flags("R10 load after reset", 4'b1111);

        // R4 corners: all-ones shifted each way
        @(negedge clk);
        flag_en = 1'b0; out_sel = 2'd2; op_a = 16'hFFFF; shift_imm_neg = 1'b0;
        #1;
        check16("R4 left fill", result, 16'hFFFE);
        shift_imm_neg = 1'b1;
        #1;
        check16("R4 right fill", result, 16'h7FFF);
        @(posedge clk);
        #1;
        check_flags("R10 hold", 4'b1111);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule